// File: doc/BRIEF.md
# Dual-Issue Scoreboard Issue Stage

This block sits between a two-wide decoder and three execution units (integer, floating-point, branch) of a superscalar core. Each clock it looks at the decoded pair of instructions held at its inputs and decides which of them may begin execution. An instruction is held back when a register it reads or writes is still awaiting a result, or when the execution unit it needs is busy. Each register has a lock bit: issuing a writer sets the bit, and a write-back notification clears it.

The pair issues in program order. The older slot goes first. The younger slot may go in the same clock only if it needs a different unit and does not touch the register the older slot writes. When the two slots are split, the younger one issues in a later clock. A new pair is taken only after both slots of the current pair have issued. The upstream decoder holds the pair stable until it sees the ready pulse.

Top module: `dual_issue_sched`

## Requirements
- R1: After reset, no register is locked, no half-issued pair is pending, and nothing issues while `grp_valid_i` is low.
- R2: Unit codes are 0 (integer), 1 (floating-point) and 2 (branch). When the two slots need different free units and have no hazard, both issue in the same clock. `unit_go_o` bit u is set for each unit that receives an instruction, and `unit_from_s1_o` bit u marks the unit fed by slot 1.
- R3: When both slots need the same unit, only slot 0 issues. Slot 1 issues in the next clock if it is then unblocked.
- R4: Issuing an instruction with a nonzero destination locks that register. An instruction that reads the register does not issue while it is locked. A write-back pulse on that register in clock k lets the reader issue in clock k+1.
- R5: An instruction whose destination register is locked does not issue.
- R6: If slot 1 reads or writes slot 0's nonzero destination, slot 1 does not issue in the same clock as slot 0. It then waits for that register's lock to clear.
- R7: Issue is in order: slot 1 never issues while slot 0 of the same pair has not issued.
- R8: `grp_ready_o` is high exactly in the clock in which the last pending slot of the pair issues. Nothing issues while `grp_valid_i` is low.
- R9: A write-back clear and a new lock on the same register in the same clock leave the register locked.
- R10: Register 0 is never locked. A destination of 0 means no register write, and a source of 0 never blocks.
- R11: A slot whose unit has its `unit_busy_i` bit set does not issue, and no dispatch goes to a busy unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid_i | input | 1 | A decoded pair is present at the slot inputs |
| slot_unit_i | input | 2x2 | Unit code per slot (index 0 = older slot) |
| slot_src_a_i | input | 2x5 | First source register per slot |
| slot_src_b_i | input | 2x5 | Second source register per slot |
| slot_dst_i | input | 2x5 | Destination register per slot, 0 = none |
| unit_busy_i | input | 3 | Busy flag per execution unit |
| wb_valid_i | input | 1 | A result is being stored this clock |
| wb_reg_i | input | 5 | Register whose lock the write-back clears |
| grp_ready_o | output | 1 | Pair fully issued; the next pair may be presented |
| issue_o | output | 2 | Per-slot issue strobe |
| unit_go_o | output | 3 | Per-unit dispatch strobe |
| unit_from_s1_o | output | 3 | Per-unit flag: dispatch comes from slot 1 |

## Verification
The hardest state to reach is a pair that is half issued: slot 0 has gone, and slot 1 is then held by the lock that slot 0 itself just set. Only a write-back on that one register releases it. The stimulus builds this state on purpose. It presents a pair in which slot 1 reads or writes slot 0's destination, checks the split and the stall, and only then pulses the write-back. It also lines up a write-back and a new lock on the same register in one clock to test which of the two wins. A sweep over every unit pair and every busy mask covers the structural split.

// File: rtl/issue_pkg.sv
package issue_pkg;
    typedef enum logic [1:0] {
        UNIT_INT = 2'd0,
        UNIT_FP  = 2'd1,
        UNIT_BR  = 2'd2
    } unit_e;
endpackage

// File: rtl/issue_lock_table.sv
module issue_lock_table #(
    parameter int NREG = 32,
    localparam int RW = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          set_en_i,
    input  logic [1:0][RW-1:0]  set_reg_i,
    input  logic                clr_en_i,
    input  logic [RW-1:0]       clr_reg_i,
    output logic [NREG-1:0]     lock_o
);
    typedef struct packed {
        logic [NREG-1:0] bits;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en_i) st_d.bits[clr_reg_i] = 1'b0;
        // a new lock wins over a clear that lands in the same clock
        for (int s = 0; s < 2; s++) begin
            if (set_en_i[s]) st_d.bits[set_reg_i[s]] = 1'b1;
        end
        st_d.bits[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.bits;
endmodule

// File: rtl/issue_slot_check.sv
module issue_slot_check #(
    parameter int NREG  = 32,
    parameter int NUNIT = 3,
    localparam int RW = $clog2(NREG),
    localparam int UW = $clog2(NUNIT)
) (
    input  logic [NREG-1:0]  lock_i,
    input  logic [RW-1:0]    src_a_i,
    input  logic [RW-1:0]    src_b_i,
    input  logic [RW-1:0]    dst_i,
    input  logic [UW-1:0]    unit_i,
    input  logic [NUNIT-1:0] busy_i,
    output logic             clear_o,
    output logic [NUNIT-1:0] unit_hot_o
);
    logic regs_free;

    always_comb begin
        unit_hot_o = '0;
        for (int u = 0; u < NUNIT; u++) begin
            if (unit_i == UW'(u)) unit_hot_o[u] = 1'b1;
        end
        regs_free = !lock_i[src_a_i] && !lock_i[src_b_i] && !lock_i[dst_i];
        clear_o   = regs_free && (|unit_hot_o) && !(|(unit_hot_o & busy_i));
    end
endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched #(
    parameter int NREG  = 32,
    parameter int NUNIT = 3,
    localparam int RW = $clog2(NREG),
    localparam int UW = $clog2(NUNIT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grp_valid_i,
    input  logic [1:0][UW-1:0]  slot_unit_i,
    input  logic [1:0][RW-1:0]  slot_src_a_i,
    input  logic [1:0][RW-1:0]  slot_src_b_i,
    input  logic [1:0][RW-1:0]  slot_dst_i,
    input  logic [NUNIT-1:0]    unit_busy_i,
    input  logic                wb_valid_i,
    input  logic [RW-1:0]       wb_reg_i,
    output logic                grp_ready_o,
    output logic [1:0]          issue_o,
    output logic [NUNIT-1:0]    unit_go_o,
    output logic [NUNIT-1:0]    unit_from_s1_o
);
    typedef struct packed {
        logic half;   // slot 0 of the held pair has already issued
    } pair_state_t;

    pair_state_t st_d, st_q;

    logic [NREG-1:0]          locks;
    logic [1:0]               slot_clear;
    logic [1:0][NUNIT-1:0]    slot_hot;
    logic                     s0_go, s1_go, intra_dep, unit_clash;
    logic [1:0]               set_en;

    for (genvar s = 0; s < 2; s++) begin : g_slot
        issue_slot_check #(.NREG(NREG), .NUNIT(NUNIT)) u_chk (
            .lock_i     (locks),
            .src_a_i    (slot_src_a_i[s]),
            .src_b_i    (slot_src_b_i[s]),
            .dst_i      (slot_dst_i[s]),
            .unit_i     (slot_unit_i[s]),
            .busy_i     (unit_busy_i),
            .clear_o    (slot_clear[s]),
            .unit_hot_o (slot_hot[s])
        );
    end

    always_comb begin
        st_d = st_q;

        intra_dep = (slot_dst_i[0] != '0) &&
                    ((slot_src_a_i[1] == slot_dst_i[0]) ||
                     (slot_src_b_i[1] == slot_dst_i[0]) ||
                     (slot_dst_i[1]   == slot_dst_i[0]));
        unit_clash = |(slot_hot[0] & slot_hot[1]);

        s0_go = grp_valid_i && !st_q.half && slot_clear[0];
        s1_go = grp_valid_i && slot_clear[1] &&
                (st_q.half || (s0_go && !unit_clash && !intra_dep));

        if (s1_go)      st_d.half = 1'b0;
        else if (s0_go) st_d.half = 1'b1;

        set_en[0] = s0_go && (slot_dst_i[0] != '0);
        set_en[1] = s1_go && (slot_dst_i[1] != '0);

        issue_o        = {s1_go, s0_go};
        grp_ready_o    = s1_go;
        unit_go_o      = (s0_go ? slot_hot[0] : '0) | (s1_go ? slot_hot[1] : '0);
        unit_from_s1_o = s1_go ? slot_hot[1] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    issue_lock_table #(.NREG(NREG)) u_locks (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en_i  (set_en),
        .set_reg_i (slot_dst_i),
        .clr_en_i  (wb_valid_i),
        .clr_reg_i (wb_reg_i),
        .lock_o    (locks)
    );
endmodule

// File: rtl/issue_sched_checker.sv
module issue_sched_checker #(
    parameter int NREG  = 32,
    parameter int NUNIT = 3,
    localparam int RW = $clog2(NREG),
    localparam int UW = $clog2(NUNIT)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                grp_valid_i,
    input logic [1:0][UW-1:0]  slot_unit_i,
    input logic [1:0][RW-1:0]  slot_src_a_i,
    input logic [1:0][RW-1:0]  slot_src_b_i,
    input logic [1:0][RW-1:0]  slot_dst_i,
    input logic [NUNIT-1:0]    unit_busy_i,
    input logic [1:0]          issue_o,
    input logic [NUNIT-1:0]    unit_go_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                        pend_q <= 1'b0;
        else if (issue_o == 2'b01)         pend_q <= 1'b1;
        else if (issue_o[1])               pend_q <= 1'b0;
    end

    p_same_unit_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o == 2'b11 |-> slot_unit_i[0] != slot_unit_i[1]);

    p_no_pair_dep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o == 2'b11 && slot_dst_i[0] != '0) |->
        (slot_src_a_i[1] != slot_dst_i[0] && slot_src_b_i[1] != slot_dst_i[0] &&
         slot_dst_i[1] != slot_dst_i[0]));

    p_in_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o[1] && !issue_o[0]) |-> pend_q);

    p_no_reissue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o[0] |-> !pend_q);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid_i |-> issue_o == 2'b00);

    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_go_o & unit_busy_i) == '0);

    p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o[0] && slot_dst_i[0] != '0) |=>
        !(issue_o[0] && (slot_src_a_i[0] == $past(slot_dst_i[0]) ||
                         slot_src_b_i[0] == $past(slot_dst_i[0]))));
endmodule

bind dual_issue_sched issue_sched_checker #(.NREG(NREG), .NUNIT(NUNIT)) u_sched_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .grp_valid_i  (grp_valid_i),
    .slot_unit_i  (slot_unit_i),
    .slot_src_a_i (slot_src_a_i),
    .slot_src_b_i (slot_src_b_i),
    .slot_dst_i   (slot_dst_i),
    .unit_busy_i  (unit_busy_i),
    .issue_o      (issue_o),
    .unit_go_o    (unit_go_o)
);

// File: tb/test_dual_issue_sched.sv
module test_dual_issue_sched;
    import issue_pkg::*;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            grp_valid = 1'b0;
    logic [1:0][1:0] s_unit = '0;
    logic [1:0][4:0] s_a = '0, s_b = '0, s_d = '0;
    logic [2:0]      busy = '0;
    logic            wb_valid = 1'b0;
    logic [4:0]      wb_reg = '0;
    logic            grp_ready;
    logic [1:0]      issue;
    logic [2:0]      unit_go, from_s1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dual_issue_sched i_dual_issue_sched (
        .clk(clk), .rst_n(rst_n), .grp_valid_i(grp_valid),
        .slot_unit_i(s_unit), .slot_src_a_i(s_a), .slot_src_b_i(s_b),
        .slot_dst_i(s_d), .unit_busy_i(busy), .wb_valid_i(wb_valid),
        .wb_reg_i(wb_reg), .grp_ready_o(grp_ready), .issue_o(issue),
        .unit_go_o(unit_go), .unit_from_s1_o(from_s1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // advance to just after a rising edge; inputs change here, samples 2 ns later
    task automatic cyc;
        @(posedge clk);
        #1;
    endtask

    task automatic set_grp(input logic [1:0] u0, input logic [4:0] a0, input logic [4:0] b0,
                           input logic [4:0] d0, input logic [1:0] u1, input logic [4:0] a1,
                           input logic [4:0] b1, input logic [4:0] d1);
        s_unit[0] = u0; s_a[0] = a0; s_b[0] = b0; s_d[0] = d0;
        s_unit[1] = u1; s_a[1] = a1; s_b[1] = b1; s_d[1] = d1;
        grp_valid = 1'b1;
    endtask

    task automatic wb_clear(input logic [4:0] r);
        cyc; grp_valid = 1'b0; wb_valid = 1'b1; wb_reg = r;
        cyc; wb_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc; #2;
        chk("R1 idle after reset", {30'd0, issue}, 0);
        chk("R1 no dispatch after reset", {29'd0, unit_go}, 0);

        // sweep every unit pair and busy mask; independent registers, no writes
        for (int u0 = 0; u0 < 3; u0++) begin
            for (int u1 = 0; u1 < 3; u1++) begin
                for (int bm = 0; bm < 8; bm++) begin
                    logic e0, e1;
                    logic [2:0] eg, es;
                    logic done;
                    cyc;
                    set_grp(2'(u0), 5'd1, 5'd2, 5'd0, 2'(u1), 5'd3, 5'd4, 5'd0);
                    busy = 3'(bm);
                    #2;
                    e0 = !busy[u0];
                    e1 = e0 && (u0 != u1) && !busy[u1];
                    eg = (e0 ? 3'(1 << u0) : 3'd0) | (e1 ? 3'(1 << u1) : 3'd0);
                    es = e1 ? 3'(1 << u1) : 3'd0;
                    chk("R2 R3 R11 issue", {30'd0, issue}, {30'd0, e1, e0});
                    chk("R2 R11 unit_go", {29'd0, unit_go}, {29'd0, eg});
                    chk("R2 unit_from_s1", {29'd0, from_s1}, {29'd0, es});
                    chk("R8 ready", {31'd0, grp_ready}, {31'd0, e1});
                    done = e1;
                    for (int k = 0; k < 3 && !done; k++) begin
                        cyc; busy = 3'd0; #2;
                        done = grp_ready;
                    end
                    chk("R3 pair completes", {31'd0, done}, 1);
                end
            end
        end
        cyc; grp_valid = 1'b0; busy = '0;

        // R4 and R7: reader of a locked register stalls, younger slot with it
        cyc; set_grp(UNIT_INT, 5'd1, 5'd2, 5'd5, UNIT_FP, 5'd3, 5'd0, 5'd6); #2;
        chk("R2 independent pair", {30'd0, issue}, 3);
        cyc; set_grp(UNIT_INT, 5'd5, 5'd0, 5'd7, UNIT_FP, 5'd8, 5'd0, 5'd9); #2;
        chk("R4 R7 reader stalls", {30'd0, issue}, 0);
        cyc; #2;
        chk("R4 still stalled", {30'd0, issue}, 0);
        cyc; wb_valid = 1'b1; wb_reg = 5'd5; #2;
        chk("R4 wb clock still stalled", {30'd0, issue}, 0);
        cyc; wb_valid = 1'b0; #2;
        chk("R4 issues after wb", {30'd0, issue}, 3);
        wb_clear(5'd6); wb_clear(5'd7); wb_clear(5'd9);

        // R3 then R5: lock r6 via a same-unit split, then a writer of r6 stalls
        cyc; set_grp(UNIT_INT, 5'd0, 5'd0, 5'd6, UNIT_INT, 5'd0, 5'd0, 5'd0); #2;
        chk("R3 first only", {30'd0, issue}, 1);
        chk("R8 not ready mid pair", {31'd0, grp_ready}, 0);
        cyc; #2;
        chk("R3 second next clock", {30'd0, issue}, 2);
        chk("R8 ready on completion", {31'd0, grp_ready}, 1);
        chk("R2 slot1 feeds int", {29'd0, from_s1}, 1);
        cyc; set_grp(UNIT_FP, 5'd1, 5'd0, 5'd6, UNIT_BR, 5'd0, 5'd0, 5'd0); #2;
        chk("R5 locked destination stalls", {30'd0, issue}, 0);
        cyc; wb_valid = 1'b1; wb_reg = 5'd6; #2;
        chk("R5 wb clock", {30'd0, issue}, 0);
        cyc; wb_valid = 1'b0; #2;
        chk("R5 issues after wb", {30'd0, issue}, 3);
        wb_clear(5'd6);

        // R6 read dependence inside the pair
        cyc; set_grp(UNIT_INT, 5'd0, 5'd0, 5'd10, UNIT_FP, 5'd10, 5'd0, 5'd11); #2;
        chk("R6 read dep split", {30'd0, issue}, 1);
        cyc; #2;
        chk("R6 waits on lock", {30'd0, issue}, 0);
        cyc; wb_valid = 1'b1; wb_reg = 5'd10; #2;
        chk("R6 wb clock", {30'd0, issue}, 0);
        cyc; wb_valid = 1'b0; #2;
        chk("R6 slot1 issues", {30'd0, issue}, 2);
        chk("R8 ready after split", {31'd0, grp_ready}, 1);
        wb_clear(5'd11);

        // R6 write-after-write inside the pair
        cyc; set_grp(UNIT_INT, 5'd0, 5'd0, 5'd13, UNIT_FP, 5'd0, 5'd0, 5'd13); #2;
        chk("R6 same dst split", {30'd0, issue}, 1);
        cyc; #2;
        chk("R6 same dst waits", {30'd0, issue}, 0);
        cyc; wb_valid = 1'b1; wb_reg = 5'd13; #2;
        cyc; wb_valid = 1'b0; #2;
        chk("R6 same dst issues", {30'd0, issue}, 2);
        wb_clear(5'd13);

        // R9: clear and set of r14 in the same clock
        cyc; set_grp(UNIT_INT, 5'd0, 5'd0, 5'd14, UNIT_FP, 5'd0, 5'd0, 5'd0);
        wb_valid = 1'b1; wb_reg = 5'd14; #2;
        chk("R9 pair issues", {30'd0, issue}, 3);
        cyc; wb_valid = 1'b0;
        set_grp(UNIT_INT, 5'd14, 5'd0, 5'd0, UNIT_FP, 5'd0, 5'd0, 5'd0); #2;
        chk("R9 lock survives clear", {30'd0, issue}, 0);
        cyc; wb_valid = 1'b1; wb_reg = 5'd14; #2;
        cyc; wb_valid = 1'b0; #2;
        chk("R9 issues after later wb", {30'd0, issue}, 3);

        // R10: register 0 as destination and source never blocks
        cyc; set_grp(UNIT_INT, 5'd0, 5'd0, 5'd0, UNIT_FP, 5'd0, 5'd0, 5'd0); #2;
        chk("R10 r0 pair", {30'd0, issue}, 3);
        cyc; set_grp(UNIT_BR, 5'd0, 5'd0, 5'd0, UNIT_INT, 5'd0, 5'd0, 5'd0); #2;
        chk("R10 r0 not locked", {30'd0, issue}, 3);
        chk("R2 dispatch br and int", {29'd0, unit_go}, 5);

        // R8: nothing issues without a valid pair
        cyc; grp_valid = 1'b0; #2;
        chk("R8 idle without valid", {30'd0, issue}, 0);

        cyc;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule